// File: doc/BRIEF.md
# Key-Sequenced Watchdog Reset Controller

This block guards a system with a wide count-up timer. Software first selects the watchdog mode in a global configuration register, loads a starting count and a limit, and then arms the unit. Arming takes two control writes. Each write must carry the enable flag and one of two fixed 16-bit keys, and the keys must come in a set order. Writes that arrive before the unit is armed and that do not match the next expected key have no effect.

Once armed, the counter advances by one on every clock. Software keeps the system alive by repeating the same two-key sequence, which returns the count to zero. If the count reaches the limit, or if a control write carries a key other than the one expected, the block raises a reset request. That request stays high until the block's own reset. The armed state cannot be left by software, and while the unit is armed its configuration, count and limit are frozen.

Top module: `keyed_watchdog`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), `phase` reads 2'b00 (idle) and `rst_req` reads 0.
- R2: Register addresses: 0 is the configuration, 1 and 2 are the low and high count words, 3 and 4 are the low and high limit words, and 5 is the control. In a control write, bit 14 is the enable flag and bits 31:16 are the key. When the configuration is valid, a control write with the enable flag set and key 0xA5C6 moves the phase from idle to 2'b01 (pre-armed). A following write with the enable flag set and key 0xDA7E moves it to 2'b10 (armed).
- R3: While idle or pre-armed, a control write that does not advance the phase leaves the phase unchanged and leaves `rst_req` low. This covers a clear enable flag, a wrong key, and a repeat of 0xA5C6 in the pre-armed phase.
- R4: The configuration is valid only when bits 3:2 hold 2'b10 (watchdog mode) and bits 1:0 hold 2'b11 (both halves released). Otherwise the arming writes are ignored.
- R5: In the armed phase, a control write whose key is not 0xA5C6 sets `rst_req` at that clock edge. The phase does not change.
- R6: In the armed phase, key 0xA5C6 moves the phase to 2'b11 (service pending). From there, key 0xDA7E returns the phase to armed and clears the count to zero. Any other key in the service-pending phase, including 0xA5C6, sets `rst_req`.
- R7: While armed or service pending, the count rises by one per clock. If the count starts at C, with C not above the limit P, then `rst_req` rises P-C+1 clock edges after the arming edge. After a service, it rises P+1 edges after the clearing edge.
- R8: Once the phase is armed or service pending, the enable flag is ignored and the phase never returns to idle through a write. Keys are evaluated as in R5 and R6.
- R9: Once high, `rst_req` stays high until reset, whatever is written.
- R10: While armed or service pending, writes to the configuration, count and limit registers are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register address |
| wr_data | input | DATA_W (32) | Write data |
| phase | output | 2 | Current arming phase: 00 idle, 01 pre-armed, 10 armed, 11 service pending |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The hardest case to reach is the exact expiry edge after a service. It can only be seen by counting clock edges from the clearing write, and every register write in between spends an edge of its own. The stimulus draws a random limit and a random preloaded count, and it mixes in writes that are ignored while the unit is armed. It tracks each edge it spends so that `rst_req` is sampled one cycle before and exactly on the predicted edge. Wrong keys for each phase are drawn at random from everything except the two valid keys.

// File: rtl/kwd_pkg.sv
// Shared types and constants for the keyed watchdog.
// Assumes a 32-bit write port; the key and enable positions are fixed.
package kwd_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_PRE  = 2'b01,
        PH_ACT  = 2'b10,
        PH_SVC  = 2'b11
    } phase_t;

    localparam int          KEY_W    = 16;
    localparam int          KEY_LSB  = 16;
    localparam int          EN_BIT   = 14;
    localparam logic [15:0] KEY_ARM  = 16'hA5C6;
    localparam logic [15:0] KEY_GO   = 16'hDA7E;
    localparam logic [1:0]  MODE_WD  = 2'b10;
    localparam int          CFG_W    = 4;
endpackage

// File: rtl/kwd_cfg_reg.sv
// Global configuration register: a timer mode field and two release bits.
// Assumes the caller gates the write strobe with the lock condition.
module kwd_cfg_reg
    import kwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] wr_bits,
    output logic             cfg_ok
);
    logic [1:0] mode_q;
    logic [1:0] rel_q;

    // Capture the mode and release fields on a permitted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            rel_q  <= '0;
        end else if (wr) begin
            mode_q <= wr_bits[3:2];
            rel_q  <= wr_bits[1:0];
        end
    end

    // Valid only in watchdog mode with both halves released.
    always_comb cfg_ok = (mode_q == MODE_WD) && (&rel_q);
endmodule

// File: rtl/kwd_key_fsm.sv
// Key-sequence state machine: idle -> pre-armed -> armed, with service loop.
// Assumes ctrl_wr is a single-cycle strobe for the control register.
module kwd_key_fsm
    import kwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             en_bit,
    input  logic [KEY_W-1:0] key,
    input  logic             cfg_ok,
    output phase_t           phase,
    output logic             bad_key,
    output logic             svc_clr
);
    phase_t phase_q, phase_d;

    // Next-phase and event decode for one control write.
    always_comb begin
        phase_d = phase_q;
        bad_key = 1'b0;
        svc_clr = 1'b0;
        if (ctrl_wr) begin
            unique case (phase_q)
                PH_IDLE: if (cfg_ok && en_bit && key == KEY_ARM) phase_d = PH_PRE;
                PH_PRE:  if (cfg_ok && en_bit && key == KEY_GO)  phase_d = PH_ACT;
                PH_ACT: begin
                    if (key == KEY_ARM) phase_d = PH_SVC;
                    else                bad_key = 1'b1;
                end
                PH_SVC: begin
                    if (key == KEY_GO) begin
                        phase_d = PH_ACT;
                        svc_clr = 1'b1;
                    end else begin
                        bad_key = 1'b1;
                    end
                end
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;
endmodule

// File: rtl/kwd_counter.sv
// Wide count-up counter with a limit register and equality compare.
// Assumes CNT_W is a multiple of DATA_W; segment writes are pre-gated.
module kwd_counter #(
    parameter int CNT_W  = 64,
    parameter int DATA_W = 32,
    localparam int NSEG  = CNT_W / DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSEG-1:0]   cnt_wr,
    input  logic [NSEG-1:0]   prd_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              run,
    input  logic              clr,
    output logic              hit
);
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  prd_flat;
    logic [DATA_W-1:0] prd_seg [NSEG];

    // One limit word per segment.
    for (genvar g = 0; g < NSEG; g++) begin : g_prd
        always_ff @(posedge clk) begin
            if (!rst_n)        prd_seg[g] <= '0;
            else if (prd_wr[g]) prd_seg[g] <= wr_data;
        end
        assign prd_flat[g*DATA_W +: DATA_W] = prd_seg[g];
    end

    // Count register: clear beats count, count beats software load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            for (int i = 0; i < NSEG; i++) begin
                if (cnt_wr[i]) cnt_q[i*DATA_W +: DATA_W] <= wr_data;
            end
        end
    end

    // Expiry compare on the current count.
    always_comb hit = (cnt_q == prd_flat);
endmodule

// File: rtl/keyed_watchdog.sv
// Top of the keyed watchdog: address decode, lock, and sticky reset request.
// Assumes one write per cycle; the register map is derived from the counter width.
module keyed_watchdog #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [1:0]        phase,
    output logic              rst_req
);
    import kwd_pkg::*;

    localparam int NSEG      = CNT_W / DATA_W;
    localparam int CFG_ADDR  = 0;
    localparam int CNT_BASE  = 1;
    localparam int PRD_BASE  = CNT_BASE + NSEG;
    localparam int CTRL_ADDR = PRD_BASE + NSEG;

    phase_t          ph;
    logic            locked;
    logic            cfg_ok;
    logic            ctrl_wr;
    logic            bad_key;
    logic            svc_clr;
    logic            hit;
    logic            run;
    logic            rst_req_q;
    logic [NSEG-1:0] cnt_wr;
    logic [NSEG-1:0] prd_wr;

    // Lock the setup registers once the unit is armed.
    always_comb begin
        locked  = (ph == PH_ACT) || (ph == PH_SVC);
        ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
        run     = locked && !rst_req_q;
    end

    // Per-segment write strobes for count and limit.
    for (genvar g = 0; g < NSEG; g++) begin : g_dec
        assign cnt_wr[g] = wr_en && !locked && (wr_addr == ADDR_W'(CNT_BASE + g));
        assign prd_wr[g] = wr_en && !locked && (wr_addr == ADDR_W'(PRD_BASE + g));
    end

    kwd_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_en && !locked && (wr_addr == ADDR_W'(CFG_ADDR))),
        .wr_bits (wr_data[CFG_W-1:0]),
        .cfg_ok  (cfg_ok)
    );

    kwd_key_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .en_bit  (wr_data[EN_BIT]),
        .key     (wr_data[KEY_LSB +: KEY_W]),
        .cfg_ok  (cfg_ok),
        .phase   (ph),
        .bad_key (bad_key),
        .svc_clr (svc_clr)
    );

    kwd_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_wr  (cnt_wr),
        .prd_wr  (prd_wr),
        .wr_data (wr_data),
        .run     (run),
        .clr     (svc_clr),
        .hit     (hit)
    );

    // Sticky reset request: set on a bad key or on expiry while armed.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rst_req_q <= 1'b0;
        else if (bad_key || (locked && hit)) rst_req_q <= 1'b1;
    end

    assign phase   = ph;
    assign rst_req = rst_req_q;
endmodule

// File: rtl/kwd_checker.sv
// Property checker for keyed_watchdog, attached through bind.
module kwd_checker
    import kwd_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int CTRL_ADDR = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [KEY_W-1:0]  key,
    input logic [1:0]        phase,
    input logic              rst_req
);
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    p_idle_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |=> (phase == PH_IDLE || phase == PH_PRE));

    p_no_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[1]) |=> (phase[1]));

    p_bad_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(CTRL_ADDR) && phase == PH_ACT && key != KEY_ARM)
        |=> (rst_req && phase == PH_ACT));

    p_svc_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(CTRL_ADDR) && phase == PH_SVC && key != KEY_GO)
        |=> rst_req);

    p_quiet_unarmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase[1]) |-> !rst_req);
endmodule

bind keyed_watchdog kwd_checker #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .key     (wr_data[kwd_pkg::KEY_LSB +: kwd_pkg::KEY_W]),
    .phase   (phase),
    .rst_req (rst_req)
);

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A_CFG = 3'd0, A_CNT_LO = 3'd1, A_CNT_HI = 3'd2,
                           A_PRD_LO = 3'd3, A_PRD_HI = 3'd4, A_CTRL = 3'd5;
    localparam logic [15:0] K_ARM = 16'hA5C6, K_GO = 16'hDA7E;
    localparam logic [31:0] CFG_GOOD = 32'h0000_000B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  phase;
    logic        rst_req;

    int checks = 0;
    int fails  = 0;

    keyed_watchdog uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .phase(phase), .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl(input logic en, input logic [15:0] k);
        return {k, 1'b0, en, 14'h0};
    endfunction

    function automatic logic [15:0] wrong_key();
        logic [15:0] k;
        k = 16'($urandom);
        while (k == K_ARM || k == K_GO) k = 16'($urandom);
        return k;
    endfunction

    // Expected edges from arming until the request rises.
    function automatic int expiry_edges(input int lim, input int start);
        return lim - start + 1;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic setup_and_arm(input int lim, input int start);
        wr(A_CFG, CFG_GOOD);
        wr(A_PRD_LO, 32'(lim)); wr(A_PRD_HI, 32'h0);
        wr(A_CNT_LO, 32'(start)); wr(A_CNT_HI, 32'h0);
        wr(A_CTRL, ctrl(1'b1, K_ARM));
        wr(A_CTRL, ctrl(1'b1, K_GO));
    endtask

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();
        chk("R1 phase", phase, 2'b00);
        chk("R1 rst_req", rst_req, 1'b0);

        // R4: invalid configurations block arming
        wr(A_CTRL, ctrl(1'b1, K_ARM));
        chk("R4 cfg zero", phase, 2'b00);
        wr(A_CFG, 32'h7);
        wr(A_CTRL, ctrl(1'b1, K_ARM));
        chk("R4 mode wrong", phase, 2'b00);
        wr(A_CFG, 32'h9);
        wr(A_CTRL, ctrl(1'b1, K_ARM));
        chk("R4 half held", phase, 2'b00);

        // R3 / R2: ignored writes and the arming sequence
        wr(A_CFG, CFG_GOOD);
        wr(A_PRD_LO, 32'd5000);
        wr(A_CTRL, ctrl(1'b0, K_ARM));
        chk("R3 no enable idle", phase, 2'b00);
        for (int i = 0; i < 6; i++) begin
            wr(A_CTRL, ctrl(1'b1, wrong_key()));
            chk("R3 wrong key idle", phase, 2'b00);
        end
        wr(A_CTRL, ctrl(1'b1, K_ARM));
        chk("R2 pre-armed", phase, 2'b01);
        for (int i = 0; i < 6; i++) begin
            wr(A_CTRL, ctrl(1'b1, wrong_key()));
            chk("R3 wrong key pre", phase, 2'b01);
        end
        wr(A_CTRL, ctrl(1'b1, K_ARM));
        chk("R3 repeat arm key", phase, 2'b01);
        wr(A_CTRL, ctrl(1'b0, K_GO));
        chk("R3 go without enable", phase, 2'b01);
        chk("R3 no request", rst_req, 1'b0);
        wr(A_CTRL, ctrl(1'b1, K_GO));
        chk("R2 armed", phase, 2'b10);

        // R8: enable flag ignored once armed
        wr(A_CTRL, ctrl(1'b0, K_ARM));
        chk("R8 service without enable", phase, 2'b11);
        wr(A_CTRL, ctrl(1'b0, K_GO));
        chk("R8 back to armed", phase, 2'b10);
        chk("R8 no request", rst_req, 1'b0);

        // R7: random limits and start counts
        for (int t = 0; t < 8; t++) begin
            int lim, st, n;
            lim = 5 + int'($urandom_range(60));
            st  = int'($urandom_range(lim));
            do_reset();
            setup_and_arm(lim, st);
            n = expiry_edges(lim, st);
            edges(n - 1);
            chk("R7 before expiry", rst_req, 1'b0);
            edges(1);
            chk("R7 at expiry", rst_req, 1'b1);
            chk("R7 phase kept", phase, 2'b10);
        end

        // R6: service clears the count
        do_reset();
        setup_and_arm(40, 0);
        edges(10);
        wr(A_CTRL, ctrl(1'b1, K_ARM));
        chk("R6 service pending", phase, 2'b11);
        edges(5);
        wr(A_CTRL, ctrl(1'b1, K_GO));
        chk("R6 serviced", phase, 2'b10);
        edges(40);
        chk("R6 before expiry", rst_req, 1'b0);
        edges(1);
        chk("R6 expiry after service", rst_req, 1'b1);

        // R6: wrong key while service pending
        do_reset();
        setup_and_arm(3000, 0);
        wr(A_CTRL, ctrl(1'b1, K_ARM));
        wr(A_CTRL, ctrl(1'b1, K_ARM));
        chk("R6 repeat arm key fires", rst_req, 1'b1);

        // R5: random wrong keys while armed
        for (int t = 0; t < 6; t++) begin
            logic [15:0] k;
            do_reset();
            setup_and_arm(3000, 0);
            k = (t == 0) ? K_GO : wrong_key();
            chk("R5 quiet before", rst_req, 1'b0);
            wr(A_CTRL, ctrl(1'($urandom), k));
            chk("R5 bad key fires", rst_req, 1'b1);
            chk("R5 phase kept", phase, 2'b10);
        end

        // R9: sticky until reset
        wr(A_CTRL, ctrl(1'b1, K_ARM));
        wr(A_CTRL, ctrl(1'b1, K_GO));
        edges(20);
        chk("R9 still high", rst_req, 1'b1);
        do_reset();
        chk("R9 cleared by reset", rst_req, 1'b0);
        chk("R9 phase idle", phase, 2'b00);

        // R10: setup writes ignored while armed
        setup_and_arm(30, 0);
        wr(A_PRD_LO, 32'd2);
        wr(A_CNT_LO, 32'd29);
        wr(A_CFG, 32'h0);
        edges(30 - 3);
        chk("R10 before expiry", rst_req, 1'b0);
        edges(1);
        chk("R10 expiry unchanged", rst_req, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule